// File: doc/BRIEF.md
# Accumulator Rotate and Carry-Flag Unit

This block is a single-cycle execution slice for the accumulator-only byte operations of an 8-bit processor core: the four one-position accumulator rotates (circular and through-carry, in both directions), accumulator inversion, forcing the carry flag, and complementing the carry flag. It also carries out the 16-bit register-pair addition, which has its own flag rules: the sign, zero and parity/overflow flags survive it, while carry and half-carry are regenerated.

Each operation is presented on one cycle together with the current accumulator, the current flag byte, two 16-bit operands and a 3-bit operation code. The new accumulator, the new flag byte and the 16-bit sum are captured in a single register stage and appear one clock later with a valid strobe. Decode, memory access and the prefixed shift group of other registers lie outside this block.

The flag byte positions are fixed: S = bit 7, Z = bit 6, H (half-carry) = bit 4, P/V = bit 2, N (subtract) = bit 1, C (carry) = bit 0. Bits 5 and 3 are undocumented copy bits that travel with the flag byte.

Top module: `acc_flag_unit`

## Requirements
- R1: `outValid` rises exactly one clock after a cycle with `inValid` high and is low one clock after a cycle with `inValid` low; after reset all outputs read zero.
- R2: Operation code 0 (circular left) moves accumulator bit 7 into bit 0 and into C, shifting the other bits up by one.
- R3: Operation code 1 (circular right) moves accumulator bit 0 into bit 7 and into C, shifting the other bits down by one.
- R4: Operation code 2 (left through carry) shifts the accumulator up by one, fills bit 0 with the old C and loads C from the old bit 7.
- R5: Operation code 3 (right through carry) shifts the accumulator down by one, fills bit 7 with the old C and loads C from the old bit 0.
- R6: For operation codes 0 to 3 the flag bits 7, 6, 5, 3 and 2 are carried over unchanged and H and N read zero.
- R7: Operation code 4 (invert) returns the bitwise complement of the accumulator, sets H and N and keeps every other flag bit.
- R8: Operation code 5 (force carry) sets C, clears H and N, keeps the other flag bits and leaves the accumulator unchanged.
- R9: Operation code 6 (complement carry) clears N, loads H with the old C, inverts C, keeps the other flag bits and leaves the accumulator unchanged.
- R10: Operation code 7 (word add) returns `opA + opB` modulo 2^16, loads C from bit 16 of the full sum and H from bit 12 of `sum ^ opA ^ opB`, keeps S, Z and P/V, clears N and bits 5 and 3, and leaves the accumulator unchanged.
- R11: `sumOut` changes only after a word add; every other operation leaves it at its previous value.
- R12: While `inValid` is low, `accOut`, `flagOut` and `sumOut` hold their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation presented this cycle |
| opSel | input | 3 | Operation code 0 to 7 as listed in the requirements |
| accIn | input | 8 | Current accumulator |
| flagIn | input | 8 | Current flag byte |
| opA | input | 16 | First word-add operand |
| opB | input | 16 | Second word-add operand |
| outValid | output | 1 | Registered results valid |
| accOut | output | 8 | New accumulator |
| flagOut | output | 8 | New flag byte |
| sumOut | output | 16 | Last word-add sum |

## Verification
The hardest case to reach is the one where the preserved flag bits would hide a wrong mask: a flag byte of all zeros makes a rotate that clears too much look correct. The stimulus therefore drives every operation with flag bytes of 0xFF, 0x00 and alternating patterns, and with carry both set and clear, so that every bit that must survive or be cleared has a value that differs from the wrong answer. Word adds are steered onto the half-carry and carry boundaries (0x0FFF + 1, 0xFFFF + 1, 0x8000 + 0x8000), and non-add operations are placed directly after a word add so that a sum that fails to hold shows at `sumOut`.

// File: rtl/acc_flag_unit_pkg.sv
package acc_flag_unit_pkg;

  localparam int FLAG_W = 8;

  // Flag byte bit positions (fixed by the processor's flag layout)
  localparam int FLAG_S  = 7;
  localparam int FLAG_Z  = 6;
  localparam int FLAG_H  = 4;
  localparam int FLAG_PV = 2;
  localparam int FLAG_N  = 1;
  localparam int FLAG_C  = 0;

  localparam logic [FLAG_W-1:0] BIT_H  = FLAG_W'(1) << FLAG_H;
  localparam logic [FLAG_W-1:0] BIT_N  = FLAG_W'(1) << FLAG_N;
  localparam logic [FLAG_W-1:0] BIT_C  = FLAG_W'(1) << FLAG_C;
  localparam logic [FLAG_W-1:0] BIT_S  = FLAG_W'(1) << FLAG_S;
  localparam logic [FLAG_W-1:0] BIT_Z  = FLAG_W'(1) << FLAG_Z;
  localparam logic [FLAG_W-1:0] BIT_PV = FLAG_W'(1) << FLAG_PV;

  // Rotates drop H, N and C; word add keeps only S, Z and P/V
  localparam logic [FLAG_W-1:0] ROT_KEEP  = ~(BIT_H | BIT_N | BIT_C);
  localparam logic [FLAG_W-1:0] WADD_KEEP = BIT_S | BIT_Z | BIT_PV;

  typedef enum logic [2:0] {
    OP_ROT_LC  = 3'd0,
    OP_ROT_RC  = 3'd1,
    OP_ROT_LT  = 3'd2,
    OP_ROT_RT  = 3'd3,
    OP_INV_ACC = 3'd4,
    OP_SET_C   = 3'd5,
    OP_CMP_C   = 3'd6,
    OP_WADD    = 3'd7
  } accOp_e;

  typedef struct packed {
    logic captureMain;
    logic captureSum;
    logic validNext;
  } ctrlStrobes_t;

endpackage

// File: rtl/acc_flag_ctrl.sv
module acc_flag_ctrl
  import acc_flag_unit_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  accOp_e       opCode,
  output ctrlStrobes_t strobes,
  output logic         outValid
);

  always_comb begin
    strobes.captureMain = inValid;
    strobes.captureSum  = inValid && (opCode == OP_WADD);
    strobes.validNext   = inValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= strobes.validNext;
  end

endmodule

// File: rtl/acc_flag_datapath.sv
module acc_flag_datapath
  import acc_flag_unit_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  accOp_e            opCode,
  input  logic [DATA_W-1:0] accIn,
  input  logic [FLAG_W-1:0] flagIn,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic [DATA_W-1:0] accOut,
  output logic [FLAG_W-1:0] flagOut,
  output logic [WORD_W-1:0] sumOut
);

  localparam int MSB      = DATA_W - 1;
  localparam int HALF_BIT = WORD_W - 4;

  logic [DATA_W-1:0] accNext;
  logic [FLAG_W-1:0] flagNext;
  logic [WORD_W:0]   wideSum;
  logic [WORD_W-1:0] carryTrace;
  logic              oldCarry;

  assign wideSum    = {1'b0, opA} + {1'b0, opB};
  assign carryTrace = wideSum[WORD_W-1:0] ^ opA ^ opB;
  assign oldCarry   = flagIn[FLAG_C];

  always_comb begin
    accNext  = accIn;
    flagNext = flagIn;
    unique case (opCode)
      OP_ROT_LC: begin
        accNext  = {accIn[MSB-1:0], accIn[MSB]};
        flagNext = (flagIn & ROT_KEEP) | (accIn[MSB] ? BIT_C : '0);
      end
      OP_ROT_RC: begin
        accNext  = {accIn[0], accIn[MSB:1]};
        flagNext = (flagIn & ROT_KEEP) | (accIn[0] ? BIT_C : '0);
      end
      OP_ROT_LT: begin
        accNext  = {accIn[MSB-1:0], oldCarry};
        flagNext = (flagIn & ROT_KEEP) | (accIn[MSB] ? BIT_C : '0);
      end
      OP_ROT_RT: begin
        accNext  = {oldCarry, accIn[MSB:1]};
        flagNext = (flagIn & ROT_KEEP) | (accIn[0] ? BIT_C : '0);
      end
      OP_INV_ACC: begin
        accNext  = ~accIn;
        flagNext = flagIn | BIT_H | BIT_N;
      end
      OP_SET_C: begin
        flagNext = (flagIn & ~(BIT_H | BIT_N)) | BIT_C;
      end
      OP_CMP_C: begin
        flagNext = (flagIn & ROT_KEEP)
                 | (oldCarry ? BIT_H : '0)
                 | (oldCarry ? '0 : BIT_C);
      end
      OP_WADD: begin
        flagNext = (flagIn & WADD_KEEP)
                 | (carryTrace[HALF_BIT] ? BIT_H : '0)
                 | (wideSum[WORD_W] ? BIT_C : '0);
      end
      default: begin
        accNext  = accIn;
        flagNext = flagIn;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accOut  <= '0;
      flagOut <= '0;
    end else if (strobes.captureMain) begin
      accOut  <= accNext;
      flagOut <= flagNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  sumOut <= '0;
    else if (strobes.captureSum) sumOut <= wideSum[WORD_W-1:0];
  end

endmodule

// File: rtl/acc_flag_unit.sv
module acc_flag_unit
  import acc_flag_unit_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [2:0]        opSel,
  input  logic [DATA_W-1:0] accIn,
  input  logic [7:0]        flagIn,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic              outValid,
  output logic [DATA_W-1:0] accOut,
  output logic [7:0]        flagOut,
  output logic [WORD_W-1:0] sumOut
);

  accOp_e       opCode;
  ctrlStrobes_t strobes;

  assign opCode = accOp_e'(opSel);

  acc_flag_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opCode   (opCode),
    .strobes  (strobes),
    .outValid (outValid)
  );

  acc_flag_datapath #(
    .DATA_W (DATA_W),
    .WORD_W (WORD_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .opCode  (opCode),
    .accIn   (accIn),
    .flagIn  (flagIn),
    .opA     (opA),
    .opB     (opB),
    .accOut  (accOut),
    .flagOut (flagOut),
    .sumOut  (sumOut)
  );

endmodule

// File: rtl/acc_flag_unit_chk.sv
module acc_flag_unit_chk #(
  parameter int DATA_W = 8,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [2:0]        opSel,
  input logic [DATA_W-1:0] accIn,
  input logic [7:0]        flagIn,
  input logic [WORD_W-1:0] opA,
  input logic [WORD_W-1:0] opB,
  input logic              outValid,
  input logic [DATA_W-1:0] accOut,
  input logic [7:0]        flagOut,
  input logic [WORD_W-1:0] sumOut
);

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  p_rot_left_circ_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 3'd0) |=>
      (accOut == {$past(accIn[DATA_W-2:0]), $past(accIn[DATA_W-1])})
      && (flagOut[0] == $past(accIn[DATA_W-1])));

  p_rot_right_thru_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 3'd3) |=>
      (accOut == {$past(flagIn[0]), $past(accIn[DATA_W-1:1])})
      && (flagOut[0] == $past(accIn[0])));

  p_rot_flag_mask_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel[2] == 1'b0) |=>
      ((flagOut & 8'hEC) == ($past(flagIn) & 8'hEC)) && !flagOut[4] && !flagOut[1]);

  p_invert_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 3'd4) |=>
      (accOut == ~$past(accIn)) && flagOut[4] && flagOut[1]);

  p_set_carry_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 3'd5) |=>
      flagOut[0] && !flagOut[4] && !flagOut[1] && (accOut == $past(accIn)));

  p_cmp_carry_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 3'd6) |=>
      (flagOut[4] == $past(flagIn[0])) && (flagOut[0] != $past(flagIn[0])) && !flagOut[1]);

  p_word_sum_r10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 3'd7) |=>
      (sumOut == WORD_W'($past(opA) + $past(opB)))
      && ((flagOut & 8'hC4) == ($past(flagIn) & 8'hC4))
      && (accOut == $past(accIn)));

  p_sum_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel != 3'd7) |=> $stable(sumOut));

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(accOut) && $stable(flagOut) && $stable(sumOut)));

endmodule

bind acc_flag_unit acc_flag_unit_chk #(
  .DATA_W (DATA_W),
  .WORD_W (WORD_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .opSel    (opSel),
  .accIn    (accIn),
  .flagIn   (flagIn),
  .opA      (opA),
  .opB      (opB),
  .outValid (outValid),
  .accOut   (accOut),
  .flagOut  (flagOut),
  .sumOut   (sumOut)
);

// File: tb/acc_flag_unit_tb_top.sv
`timescale 1ns/1ps
module acc_flag_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  opSel = '0;
  logic [7:0]  accIn = '0;
  logic [7:0]  flagIn = '0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic        outValid;
  logic [7:0]  accOut;
  logic [7:0]  flagOut;
  logic [15:0] sumOut;

  always #10 clk = ~clk;

  acc_flag_unit dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .accIn(accIn), .flagIn(flagIn), .opA(opA), .opB(opB),
    .outValid(outValid), .accOut(accOut), .flagOut(flagOut), .sumOut(sumOut)
  );

  typedef struct {
    logic [7:0]  acc;
    logic [7:0]  flag;
    logic [15:0] sum;
    string       tag;
  } expItem_t;

  expItem_t    scoreQ[$];
  int          nChecks = 0;
  int          nFails = 0;
  bit          finished = 0;
  logic [15:0] sumModel = '0;
  expItem_t    lastExp;

  function automatic expItem_t predict(input logic [2:0] op, input logic [7:0] a,
                                       input logic [7:0] f, input logic [15:0] x,
                                       input logic [15:0] y, input logic [15:0] prevSum);
    expItem_t e;
    logic [16:0] full;
    logic [15:0] trace;
    e.acc = a; e.flag = f; e.sum = prevSum;
    case (op)
      3'd0: begin e.acc = {a[6:0], a[7]}; e.flag = {f[7:5], 1'b0, f[3:2], 1'b0, a[7]}; e.tag = "R2/R6"; end
      3'd1: begin e.acc = {a[0], a[7:1]}; e.flag = {f[7:5], 1'b0, f[3:2], 1'b0, a[0]}; e.tag = "R3/R6"; end
      3'd2: begin e.acc = {a[6:0], f[0]}; e.flag = {f[7:5], 1'b0, f[3:2], 1'b0, a[7]}; e.tag = "R4/R6"; end
      3'd3: begin e.acc = {f[0], a[7:1]}; e.flag = {f[7:5], 1'b0, f[3:2], 1'b0, a[0]}; e.tag = "R5/R6"; end
      3'd4: begin e.acc = ~a; e.flag = {f[7:5], 1'b1, f[3:2], 1'b1, f[0]}; e.tag = "R7"; end
      3'd5: begin e.flag = {f[7:5], 1'b0, f[3:2], 1'b0, 1'b1}; e.tag = "R8/R11"; end
      3'd6: begin e.flag = {f[7:5], f[0], f[3:2], 1'b0, ~f[0]}; e.tag = "R9/R11"; end
      default: begin
        full  = {1'b0, x} + {1'b0, y};
        trace = full[15:0] ^ x ^ y;
        e.sum  = full[15:0];
        e.flag = {f[7], f[6], 1'b0, trace[12], 1'b0, f[2], 1'b0, full[16]};
        e.tag  = "R10";
      end
    endcase
    return e;
  endfunction

  task automatic checkVal(input string tag, input string what,
                          input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic applyOp(input logic [2:0] op, input logic [7:0] a, input logic [7:0] f,
                         input logic [15:0] x, input logic [15:0] y);
    expItem_t e;
    @(negedge clk);
    inValid = 1'b1; opSel = op; accIn = a; flagIn = f; opA = x; opB = y;
    e = predict(op, a, f, x, y, sumModel);
    sumModel = e.sum;
    lastExp = e;
    scoreQ.push_back(e);
  endtask

  // R12 and R1: idle cycles with wild inputs leave every output held
  task automatic idleHold();
    @(negedge clk);
    inValid = 1'b0; opSel = 3'd7; accIn = 8'h5A; flagIn = 8'hA5;
    opA = 16'hFFFF; opB = 16'h0001;
    @(negedge clk);
    @(negedge clk);
    checkVal("R12", "idle accOut", {8'h0, accOut}, {8'h0, lastExp.acc});
    checkVal("R12", "idle flagOut", {8'h0, flagOut}, {8'h0, lastExp.flag});
    checkVal("R12", "idle sumOut", sumOut, lastExp.sum);
    checkVal("R1", "idle outValid", {15'h0, outValid}, 16'h0);
  endtask

  // Monitor: pops an expected item for every valid result
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (scoreQ.size() == 0) begin
        nChecks++; nFails++;
        $display("FAIL R1 unexpected outValid actual=1 expected=0");
      end else begin
        expItem_t e;
        e = scoreQ.pop_front();
        checkVal(e.tag, "accOut", {8'h0, accOut}, {8'h0, e.acc});
        checkVal(e.tag, "flagOut", {8'h0, flagOut}, {8'h0, e.flag});
        checkVal("R11", "sumOut", sumOut, e.sum);
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish();
  end

  initial begin
    lastExp.acc = '0; lastExp.flag = '0; lastExp.sum = '0; lastExp.tag = "R1";
    repeat (3) @(negedge clk);
    checkVal("R1", "reset outValid", {15'h0, outValid}, 16'h0);
    checkVal("R1", "reset accOut", {8'h0, accOut}, 16'h0);
    checkVal("R1", "reset flagOut", {8'h0, flagOut}, 16'h0);
    checkVal("R1", "reset sumOut", sumOut, 16'h0);
    rstN = 1'b1;

    // Rotates with preserved-bit patterns and both carry values (R2..R6)
    applyOp(3'd0, 8'h81, 8'hFF, 16'h0, 16'h0);
    applyOp(3'd0, 8'h7E, 8'h00, 16'h0, 16'h0);
    applyOp(3'd1, 8'h01, 8'hAA, 16'h0, 16'h0);
    applyOp(3'd1, 8'hFE, 8'h55, 16'h0, 16'h0);
    applyOp(3'd2, 8'h80, 8'hFE, 16'h0, 16'h0);
    applyOp(3'd2, 8'h40, 8'h01, 16'h0, 16'h0);
    applyOp(3'd3, 8'h01, 8'hFE, 16'h0, 16'h0);
    applyOp(3'd3, 8'h02, 8'h01, 16'h0, 16'h0);
    // Word-add boundaries (R10)
    applyOp(3'd7, 8'h33, 8'hFF, 16'h0FFF, 16'h0001);
    applyOp(3'd7, 8'h33, 8'hFF, 16'hFFFF, 16'h0001);
    applyOp(3'd7, 8'h44, 8'h00, 16'h8000, 16'h8000);
    // Non-add after add: sum must hold (R7, R8, R9, R11)
    applyOp(3'd4, 8'hA5, 8'h00, 16'h1111, 16'h2222);
    applyOp(3'd4, 8'h00, 8'h29, 16'h0, 16'h0);
    applyOp(3'd5, 8'h12, 8'h12, 16'h7777, 16'h7777);
    applyOp(3'd5, 8'h34, 8'hFE, 16'h0, 16'h0);
    applyOp(3'd6, 8'h56, 8'h01, 16'h0, 16'h0);
    applyOp(3'd6, 8'h78, 8'hFE, 16'h0, 16'h0);
    idleHold();

    // Mixed sweep over all operation codes
    for (int i = 0; i < 400; i++) begin
      applyOp(3'($urandom), 8'($urandom), 8'($urandom), 16'($urandom), 16'($urandom));
      if (i % 50 == 49) idleHold();
    end
    idleHold();
    finish();
  end

endmodule